// File: doc/BRIEF.md
# Sync-Started Burst PWM Generator

This block produces a pulse-width-modulated output whose cycles are not free-running: each cycle sequence is launched by a rising edge on an external sync input. Once launched, the generator runs a programmed number of PWM periods and then parks with its output low and its counter at zero. It stays there until the next sync edge. Period, duty, phase offset and a trigger-compare position are programmed through a simple register write port. Period and duty are written with four fractional low bits, so software writes the clock count shifted left by four.

Every time the running period counter equals the compare position, the block emits a one-clock converter-trigger pulse. It can also mirror that pulse on a chaining output that serves as the cycle-start source of a second instance. A rearm option decides whether a sync edge that arrives during a burst restarts the burst or is ignored.

Top module: `burst_pwm`

## Requirements
- R1: After synchronous reset all registers read as zero, the generator is idle, and `pwm_out`, `adc_trig` and `gen_trig` are low.
- R2: The register map is as follows:
  - address 0: period; clocks per cycle are the value shifted right by 4, and a result of 0 acts as 1.
  - address 1: duty; the clock count is the value shifted right by 4.
  - address 2: phase.
  - address 3: compare position.
  - address 4: burst count.
  - address 5: control, with bit0 enable, bit1 rearm and bit2 chain.

  The low 4 bits of period and duty have no effect. A write takes effect from the next clock.
- R3: While running, `pwm_out` is high exactly when phase <= counter < phase + duty. When phase + duty exceeds the period, the output stays high from phase to the end of the cycle.
- R4: A burst lasts burst count + 1 PWM cycles. Afterwards the output is low, no trigger fires and the counter rests at zero.
- R5: With enable set, a rising edge of `sync_in` starts a burst so that the counter is 0 in the cycle after the edge is sampled. Holding `sync_in` high does not start a further burst.
- R6: With rearm set, a sync edge during a burst restarts the counter and the cycle count from the beginning. With rearm clear, such an edge is ignored, but an edge while idle still starts a burst.
- R7: While running, `adc_trig` is high for one clock in each cycle where the counter equals the compare position. A compare position at or beyond the period never fires.
- R8: `gen_trig` equals `adc_trig` when the chain bit is set and is low otherwise.
- R9: Clearing enable stops the generator on the next clock with all outputs low. Sync edges are ignored while enable is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | CNT_W+FRAC_W (20) | Register write data |
| sync_in | input | 1 | External cycle-start sync, rising-edge sensitive |
| pwm_out | output | 1 | PWM output |
| adc_trig | output | 1 | Compare-match converter trigger pulse |
| gen_trig | output | 1 | Compare-match pulse for chaining a second generator |

## Verification
The bench targets the burst-length boundary (count 0 giving a single cycle), the fractional-bit stripping of period and duty, and a period register that resolves to zero. A design off by one in the burst would show one cycle too many or too few of compare pulses. A design that used the raw period value would produce far longer cycles. It also drives sync held high for a long time, and sync edges mid-burst with rearm set and clear; a level-sensitive or wrongly rearming generator would show extra trigger pulses. Finally it checks a phase-plus-duty overflow, compare positions beyond the period, and disabling mid-burst, where a wrong design would leak a trigger or leave the output high.

// File: rtl/pwmb_pkg.sv
package pwmb_pkg;

    localparam int DEF_CNT_W  = 16;
    localparam int DEF_FRAC_W = 4;
    localparam int DEF_TC_W   = 4;

    typedef enum logic [2:0] {
        SEL_PERIOD = 3'd0,
        SEL_DUTY   = 3'd1,
        SEL_PHASE  = 3'd2,
        SEL_CMP    = 3'd3,
        SEL_BURST  = 3'd4,
        SEL_CTRL   = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic chain;
        logic rearm;
        logic enable;
    } ctrl_t;

endpackage

// File: rtl/pwmb_regs.sv
module pwmb_regs
    import pwmb_pkg::*;
#(
    parameter int CNT_W  = DEF_CNT_W,
    parameter int FRAC_W = DEF_FRAC_W,
    parameter int TC_W   = DEF_TC_W,
    localparam int DW    = CNT_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [DW-1:0]    wr_data,
    output logic [CNT_W-1:0] per_clk,
    output logic [CNT_W-1:0] duty_clk,
    output logic [CNT_W-1:0] phase,
    output logic [CNT_W-1:0] cmp,
    output logic [TC_W-1:0]  burst,
    output ctrl_t            ctrl
);
    logic [DW-1:0] period_q, duty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            period_q <= '0;
            duty_q   <= '0;
            phase    <= '0;
            cmp      <= '0;
            burst    <= '0;
            ctrl     <= '0;
        end else if (wr_en) begin
            case (reg_sel_e'(wr_addr))
                SEL_PERIOD: period_q <= wr_data;
                SEL_DUTY:   duty_q   <= wr_data;
                SEL_PHASE:  phase    <= wr_data[CNT_W-1:0];
                SEL_CMP:    cmp      <= wr_data[CNT_W-1:0];
                SEL_BURST:  burst    <= wr_data[TC_W-1:0];
                SEL_CTRL:   ctrl     <= ctrl_t'(wr_data[2:0]);
                default: ;
            endcase
        end
    end

    // fractional bits are dropped: only whole clocks count
    assign per_clk  = period_q[DW-1:FRAC_W];
    assign duty_clk = duty_q[DW-1:FRAC_W];
endmodule

// File: rtl/pwmb_sync.sv
module pwmb_sync #(
    parameter bit EDGE_MODE = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic sync_in,
    output logic start_ev
);
    generate
        if (EDGE_MODE) begin : g_edge
            logic sync_q;
            always_ff @(posedge clk) begin
                if (rst) sync_q <= 1'b0;
                else     sync_q <= sync_in;
            end
            assign start_ev = sync_in & ~sync_q;
        end else begin : g_level
            assign start_ev = sync_in;
        end
    endgenerate
endmodule

// File: rtl/pwmb_core.sv
module pwmb_core
    import pwmb_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W,
    parameter int TC_W  = DEF_TC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_ev,
    input  logic [CNT_W-1:0] per_clk,
    input  logic [TC_W-1:0]  burst,
    input  ctrl_t            ctrl,
    output logic             running,
    output logic [CNT_W-1:0] cnt
);
    logic [TC_W-1:0]  left;
    logic [CNT_W-1:0] last;
    logic             launch;

    assign last   = (per_clk == '0) ? '0 : per_clk - CNT_W'(1);
    assign launch = start_ev && (!running || ctrl.rearm);

    always_ff @(posedge clk) begin
        if (rst || !ctrl.enable) begin
            running <= 1'b0;
            cnt     <= '0;
            left    <= '0;
        end else if (launch) begin
            running <= 1'b1;
            cnt     <= '0;
            left    <= burst;
        end else if (running) begin
            if (cnt >= last) begin
                cnt <= '0;
                if (left == '0) running <= 1'b0;
                else            left    <= left - TC_W'(1);
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    assert_start_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (start_ev && ctrl.enable && !running) |=> (running && cnt == '0));

    assert_cnt_in_period_R2: assert property (@(posedge clk) disable iff (rst)
        (running && $stable(per_clk)) |-> (cnt <= last));

    assert_burst_ends_R4: assert property (@(posedge clk) disable iff (rst)
        (running && left == '0 && cnt >= last && !start_ev && ctrl.enable) |=> !running);

    assert_disable_stops_R9: assert property (@(posedge clk) disable iff (rst)
        !ctrl.enable |=> (!running && cnt == '0));
endmodule

// File: rtl/pwmb_out.sv
module pwmb_out
    import pwmb_pkg::*;
#(
    parameter int CNT_W = DEF_CNT_W
) (
    input  logic             running,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] phase,
    input  logic [CNT_W-1:0] duty_clk,
    input  logic [CNT_W-1:0] cmp,
    input  ctrl_t            ctrl,
    output logic             pwm_out,
    output logic             adc_trig,
    output logic             gen_trig
);
    logic [CNT_W:0] hi_end;

    assign hi_end   = {1'b0, phase} + {1'b0, duty_clk};
    assign pwm_out  = running && (cnt >= phase) && ({1'b0, cnt} < hi_end);
    assign adc_trig = running && (cnt == cmp);
    assign gen_trig = adc_trig && ctrl.chain;
endmodule

// File: rtl/burst_pwm.sv
module burst_pwm
    import pwmb_pkg::*;
#(
    parameter int CNT_W     = DEF_CNT_W,
    parameter int FRAC_W    = DEF_FRAC_W,
    parameter int TC_W      = DEF_TC_W,
    parameter bit EDGE_MODE = 1'b1,
    localparam int DW       = CNT_W + FRAC_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [2:0]    wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          sync_in,
    output logic          pwm_out,
    output logic          adc_trig,
    output logic          gen_trig
);
    logic [CNT_W-1:0] per_clk, duty_clk, phase, cmp, cnt;
    logic [TC_W-1:0]  burst;
    ctrl_t            ctrl;
    logic             start_ev, running;

    pwmb_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .TC_W(TC_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .per_clk(per_clk), .duty_clk(duty_clk), .phase(phase), .cmp(cmp),
        .burst(burst), .ctrl(ctrl)
    );

    pwmb_sync #(.EDGE_MODE(EDGE_MODE)) u_sync (
        .clk(clk), .rst(rst), .sync_in(sync_in), .start_ev(start_ev)
    );

    pwmb_core #(.CNT_W(CNT_W), .TC_W(TC_W)) u_core (
        .clk(clk), .rst(rst), .start_ev(start_ev), .per_clk(per_clk),
        .burst(burst), .ctrl(ctrl), .running(running), .cnt(cnt)
    );

    pwmb_out #(.CNT_W(CNT_W)) u_out (
        .running(running), .cnt(cnt), .phase(phase), .duty_clk(duty_clk),
        .cmp(cmp), .ctrl(ctrl), .pwm_out(pwm_out), .adc_trig(adc_trig),
        .gen_trig(gen_trig)
    );

    assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        !running |-> (!pwm_out && !adc_trig && !gen_trig));

    assert_chain_gated_R8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.chain) |-> !gen_trig);

    assert_cmp_beyond_R7: assert property (@(posedge clk) disable iff (rst)
        (adc_trig && $stable(per_clk) && per_clk > CNT_W'(1)) |=> !adc_trig);
endmodule

// File: tb/burst_pwm_test.sv
module burst_pwm_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [19:0] wr_data = '0;
    logic        sync_in = 1'b0;
    logic        pwm_out, adc_trig, gen_trig;

    burst_pwm uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .sync_in(sync_in), .pwm_out(pwm_out), .adc_trig(adc_trig), .gen_trig(gen_trig)
    );

    always #5 clk = ~clk;

    int checks = 0, fails = 0, cycles = 0;
    string cur_req = "R1";
    int n_adc = 0, n_gen = 0, n_pwm = 0;

    // behavioural reference model
    int m_period, m_duty, m_phase, m_cmp, m_burst, m_ctrl;
    int m_cnt, m_left;
    bit m_run, m_sq;

    always @(posedge clk) begin
        if (rst) begin
            m_period = 0; m_duty = 0; m_phase = 0; m_cmp = 0; m_burst = 0; m_ctrl = 0;
            m_cnt = 0; m_left = 0; m_run = 0; m_sq = 0;
        end else begin
            int per, lst;
            bit start;
            start = sync_in && !m_sq;
            per = m_period >> 4;
            lst = (per == 0) ? 0 : per - 1;
            if ((m_ctrl & 1) == 0) begin
                m_run = 0; m_cnt = 0; m_left = 0;
            end else if (start && (!m_run || (m_ctrl & 2) != 0)) begin
                m_run = 1; m_cnt = 0; m_left = m_burst;
            end else if (m_run) begin
                if (m_cnt >= lst) begin
                    m_cnt = 0;
                    if (m_left == 0) m_run = 0; else m_left--;
                end else m_cnt++;
            end
            m_sq = sync_in;
            if (wr_en) begin
                case (wr_addr)
                    3'd0: m_period = int'(wr_data);
                    3'd1: m_duty   = int'(wr_data);
                    3'd2: m_phase  = int'(wr_data & 20'hFFFF);
                    3'd3: m_cmp    = int'(wr_data & 20'hFFFF);
                    3'd4: m_burst  = int'(wr_data & 20'hF);
                    3'd5: m_ctrl   = int'(wr_data & 20'h7);
                    default: ;
                endcase
            end
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic check(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s got %0d expected %0d", req, what, got, exp);
        end
    endtask

    // per-cycle comparison and event counting, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            fails++; checks++;
            $display("FAIL watchdog expired in %s", cur_req);
            finish_run();
        end
        if (!rst) begin
            bit e_pwm, e_adc, e_gen;
            e_pwm = m_run && (m_cnt >= m_phase) && (m_cnt < m_phase + (m_duty >> 4));
            e_adc = m_run && (m_cnt == m_cmp);
            e_gen = e_adc && ((m_ctrl & 4) != 0);
            checks++;
            if (pwm_out !== e_pwm || adc_trig !== e_adc || gen_trig !== e_gen) begin
                fails++;
                $display("FAIL %s outputs pwm/adc/gen got %b%b%b expected %b%b%b at cycle %0d",
                         cur_req, pwm_out, adc_trig, gen_trig, e_pwm, e_adc, e_gen, cycles);
            end
            n_adc += int'(adc_trig);
            n_gen += int'(gen_trig);
            n_pwm += int'(pwm_out);
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 20'(d);
        step();
        wr_en = 1'b0;
    endtask

    task automatic zero_counts();
        n_adc = 0; n_gen = 0; n_pwm = 0;
    endtask

    task automatic pulse_sync();
        sync_in = 1'b1; step(); sync_in = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        // R1 reset state
        check("R1", "pwm_out after reset", int'(pwm_out), 0);
        check("R1", "adc_trig after reset", int'(adc_trig), 0);
        check("R1", "gen_trig after reset", int'(gen_trig), 0);

        // R2: period 10 clocks with junk fractional bits; duty 4, phase 2
        cur_req = "R2";
        wr(0, (10 << 4) | 5);
        wr(1, (4 << 4) | 15);
        wr(2, 2);
        wr(3, 0);
        wr(4, 1);
        wr(5, 5);
        zero_counts();
        // R4: count 1 gives two cycles
        cur_req = "R4";
        pulse_sync();
        repeat (30) step();
        check("R4", "compare pulses in burst of 2", n_adc, 2);
        check("R3", "pwm high clocks in burst of 2", n_pwm, 8);
        check("R8", "chained pulses with chain set", n_gen, 2);

        // R5: sync held high starts only one burst
        cur_req = "R5";
        zero_counts();
        sync_in = 1'b1;
        repeat (60) step();
        sync_in = 1'b0;
        step();
        check("R5", "pulses with sync held high", n_adc, 2);

        // R6: rearm clear, mid-burst edge ignored
        cur_req = "R6";
        zero_counts();
        pulse_sync();
        repeat (5) step();
        pulse_sync();
        repeat (30) step();
        check("R6", "pulses with rearm clear", n_adc, 2);
        // rearm set: restart mid-burst
        wr(5, 7);
        zero_counts();
        pulse_sync();
        repeat (5) step();
        pulse_sync();
        repeat (30) step();
        check("R6", "pulses with rearm set", n_adc, 3);

        // R7: compare beyond period never fires, compare at last fires
        cur_req = "R7";
        wr(3, 12);
        zero_counts();
        pulse_sync();
        repeat (30) step();
        check("R7", "pulses with compare beyond period", n_adc, 0);
        wr(3, 9);
        zero_counts();
        pulse_sync();
        repeat (30) step();
        check("R7", "pulses with compare at last count", n_adc, 2);

        // R8: chain bit clear
        cur_req = "R8";
        wr(5, 3);
        zero_counts();
        pulse_sync();
        repeat (30) step();
        check("R8", "chained pulses with chain clear", n_gen, 0);
        check("R8", "compare pulses with chain clear", n_adc, 2);

        // R3: phase + duty overflow, burst count 0 gives one cycle (R4)
        cur_req = "R3";
        wr(3, 0);
        wr(2, 7);
        wr(1, 6 << 4);
        wr(4, 0);
        zero_counts();
        pulse_sync();
        repeat (20) step();
        check("R3", "pwm high clocks with overflowing duty", n_pwm, 3);
        check("R4", "pulses with burst count 0", n_adc, 1);

        // R2: period resolving to zero acts as one clock
        cur_req = "R2";
        wr(0, 3);
        wr(2, 0);
        wr(1, 1 << 4);
        wr(4, 3);
        zero_counts();
        pulse_sync();
        repeat (10) step();
        check("R2", "pulses with zero period", n_adc, 4);
        check("R2", "pwm clocks with zero period", n_pwm, 4);

        // R9: disable mid-burst, then sync ignored while disabled
        cur_req = "R9";
        wr(0, 10 << 4);
        wr(4, 2);
        wr(5, 7);
        pulse_sync();
        repeat (3) step();
        wr(5, 6);
        zero_counts();
        repeat (5) step();
        pulse_sync();
        repeat (30) step();
        check("R9", "pulses while disabled", n_adc, 0);
        check("R9", "pwm clocks while disabled", n_pwm, 0);

        finish_run();
    end
endmodule